// File: doc/BRIEF.md
# Supply-Good Reset Sequencer with Watchdog

This block produces the active-low system reset for a processor subsystem. Its inputs are a digital flag from an external supply comparator and a watchdog input. Reset stays asserted while the power-on flag is low or while the supply flag reports the rail below its threshold. A low excursion on the supply flag is treated as a real failure only when it lasts a programmable minimum number of cycles. Once the filtered supply is good again, a fixed release delay runs, and reset deasserts when that delay ends. Any dip during the delay restarts it.

After release, the processor must toggle the watchdog input, and either edge counts as a service. If no edge arrives within the timeout window, the block asserts reset for exactly one release delay and then deasserts it. A strap input marks the watchdog input as unconnected. In that mode the watchdog retriggers itself at seven eighths of the window and never times out.

The supply flag and the watchdog input come from asynchronous sources. Each passes through a synchronizer of `SYNC_STAGES` flops (default 2) before filtering or edge detection. The strap is taken to be static. All lengths are parameters counted in clock cycles.

Top module: `supv_reset_ctrl`

## Requirements
- R1: `sys_rst_n` is 0 in the cycle after any clock edge that samples `por_n` at 0, and it stays 0 for as long as `por_n` is 0, whatever the other inputs do.
- R2: After `supply_ok` rises and stays at 1, `sys_rst_n` goes to 1 exactly `RELEASE_CYC + 3` clock edges after the change at the pin. This is 2 synchronizer edges, 1 filter edge and the release delay.
- R3: If the filtered supply fails while the release delay is running, the delay restarts. `sys_rst_n` stays 0 and then rises exactly `RELEASE_CYC + 3` edges after the final rise of `supply_ok`.
- R4: A low pulse on `supply_ok` lasting fewer than `DIP_CYC` cycles leaves `sys_rst_n` at 1. A low pulse of `DIP_CYC` cycles or more drives `sys_rst_n` to 0 exactly `DIP_CYC + 3` edges after the falling change at the pin.
- R5: Either a rising or a falling change on `wdi` restarts the watchdog window. With `wd_open` = 0 and no further change, `sys_rst_n` falls exactly `TIMEOUT_CYC + 3` edges after the last change at the pin. Changes spaced at most `TIMEOUT_CYC - 1` cycles apart keep `sys_rst_n` at 1.
- R6: A watchdog timeout holds `sys_rst_n` at 0 for exactly `RELEASE_CYC` cycles, after which it returns to 1.
- R7: While `wd_open` = 1 and the supply is good, the watchdog never asserts reset, whatever `wdi` does.
- R8: The watchdog count is held at zero while reset is asserted. After every release, with no `wdi` change, the timeout occurs exactly `TIMEOUT_CYC` edges after `sys_rst_n` rises, including when `wdi` changed during the reset period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on flag, active low; synchronous reset of all state |
| supply_ok | input | 1 | Asynchronous comparator flag, 1 = supply above threshold |
| wdi | input | 1 | Asynchronous watchdog service input, either edge services |
| wd_open | input | 1 | Static strap, 1 = watchdog input unconnected (self-retrigger) |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The embedded properties check several rules on every cycle. Reset follows a failed filtered supply and every timeout on the next edge. Release only ever follows a cycle of good supply. The filter output cannot fall while the synchronized flag is high. A service edge or an asserted reset clears the watchdog count. The open strap never lets a timeout through. The exact latencies can only be shown by the bench scenarios: release after `RELEASE_CYC + 3` edges, failure after `DIP_CYC + 3` edges, and timeout after `TIMEOUT_CYC + 3` edges. The same holds for the restart of an interrupted delay, the sweep of dip lengths around the filter limit and the sweep of service intervals with both edge polarities.

// File: rtl/supv_pkg.sv
// Package: shared types for the supervisory reset block.
// Assumes: nothing beyond standard SystemVerilog.
package supv_pkg;

    // Asynchronous inputs that share one synchronizer bank.
    typedef struct packed {
        logic supply;
        logic wdi;
    } supv_in_t;

endpackage

// File: rtl/supv_sync.sv
// Module: multi-bit, multi-stage synchronizer chain, one flop row per stage.
// Assumes: each bit is independent (no bus coherency needed); reset clears to 0.
module supv_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each further stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[gi] <= '0;
                else        stg[gi] <= stg[gi-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/supv_filter.sv
// Module: minimum-duration filter on the synchronized supply flag.
// Good rises at once on a high sample and falls only after DIP_CYC
// consecutive low samples. Assumes: DIP_CYC >= 1; flag is synchronous.
module supv_filter #(
    parameter int DIP_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag,
    output logic good
);

    localparam int CW = $clog2(DIP_CYC + 1);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples; declare failure at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good    <= 1'b0;
            low_cnt <= '0;
        end else if (flag) begin
            good    <= 1'b1;
            low_cnt <= '0;
        end else if (low_cnt == CW'(DIP_CYC - 1)) begin
            good    <= 1'b0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r4_high_keeps_good: assert property (@(posedge clk) disable iff (!rst_n)
        good && flag |=> good);
    a_r4_fall_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(good) |-> !$past(flag));

endmodule

// File: rtl/supv_watchdog.sv
// Module: watchdog window counter with either-edge service detection.
// The counter is held at zero while run = 0. When open = 1 it retriggers
// at 7/8 of the window and never expires. Assumes: wdi_s is synchronous,
// open is static, TIMEOUT_CYC >= 8.
module supv_watchdog #(
    parameter int TIMEOUT_CYC = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wdi_s,
    input  logic open,
    output logic expire
);

    localparam int CW     = $clog2(TIMEOUT_CYC + 1);
    localparam int RETRIG = (TIMEOUT_CYC * 7) / 8;

    logic          wdi_prev;
    logic          kick;
    logic [CW-1:0] wcnt;
    logic          at_end;
    logic          at_retrig;

    // Remember the last synchronized watchdog level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wdi_prev <= 1'b0;
        else        wdi_prev <= wdi_s;
    end

    assign kick      = wdi_s ^ wdi_prev;
    assign at_end    = (wcnt == CW'(TIMEOUT_CYC - 1));
    assign at_retrig = (wcnt == CW'(RETRIG - 1));
    assign expire    = run && !kick && !open && at_end;

    // Advance the window, clearing on service, reset, retrigger or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick) wcnt <= '0;
        else if (open && at_retrig) wcnt <= '0;
        else if (at_end)            wcnt <= '0;
        else                        wcnt <= wcnt + 1'b1;
    end

    a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> wcnt == '0);
    a_r8_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> wcnt == '0);

endmodule

// File: rtl/supv_sequencer.sv
// Module: reset release sequencer. Holds reset while the supply is bad,
// releases RELEASE_CYC cycles after it turns good, and reopens a full
// delay on a watchdog expiry. Assumes: good is filtered and synchronous.
module supv_sequencer #(
    parameter int RELEASE_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic good,
    input  logic wd_expire,
    output logic rst_out_n
);

    localparam int CW = $clog2(RELEASE_CYC + 1);

    logic [CW-1:0] dcnt;

    // Run the release delay and drive the registered reset output.
    always_ff @(posedge clk) begin
        if (!rst_n || !good || wd_expire) begin
            rst_out_n <= 1'b0;
            dcnt      <= '0;
        end else if (!rst_out_n) begin
            if (dcnt == CW'(RELEASE_CYC - 1)) rst_out_n <= 1'b1;
            else                              dcnt      <= dcnt + 1'b1;
        end
    end

    a_r1_hold_bad_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !good |=> !rst_out_n);
    a_r6_expire_resets: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !rst_out_n);
    a_r2_release_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> $past(good));
    a_r2_delay_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt < CW'(RELEASE_CYC));

endmodule

// File: rtl/supv_reset_ctrl.sv
// Module: supervisory reset and watchdog controller (top).
// Synchronizes the supply flag and watchdog input, filters short supply
// dips, sequences the reset release and runs the watchdog.
// Assumes: por_n is a synchronous active-low power-on flag; wd_open static.
module supv_reset_ctrl #(
    parameter int RELEASE_CYC = 100000,
    parameter int TIMEOUT_CYC = 800000,
    parameter int DIP_CYC     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic wdi,
    input  logic wd_open,
    output logic sys_rst_n
);

    import supv_pkg::*;

    localparam int IW = $bits(supv_in_t);

    supv_in_t          raw_in;
    supv_in_t          syn_in;
    logic     [IW-1:0] syn_vec;
    logic              supply_good;
    logic              wd_expire;

    assign raw_in = '{supply: supply_ok, wdi: wdi};
    assign syn_in = supv_in_t'(syn_vec);

    supv_sync #(.WIDTH(IW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (raw_in),
        .q     (syn_vec)
    );

    supv_filter #(.DIP_CYC(DIP_CYC)) u_filter (
        .clk   (clk),
        .rst_n (por_n),
        .flag  (syn_in.supply),
        .good  (supply_good)
    );

    supv_sequencer #(.RELEASE_CYC(RELEASE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (por_n),
        .good      (supply_good),
        .wd_expire (wd_expire),
        .rst_out_n (sys_rst_n)
    );

    supv_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (por_n),
        .run    (sys_rst_n),
        .wdi_s  (syn_in.wdi),
        .open   (wd_open),
        .expire (wd_expire)
    );

    a_r7_open_no_timeout: assert property (@(posedge clk) disable iff (!por_n)
        wd_open && sys_rst_n && supply_good |=> sys_rst_n);

endmodule

// File: tb/supv_reset_ctrl_bench.sv
// Bench: directed sweeps over a shrunken configuration; expected latencies
// are computed from the requirement formulas. Drives and samples at negedge.
module supv_reset_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DLY  = 20;
    localparam int WDT  = 64;
    localparam int DIP  = 4;
    localparam int LIM  = 4 * WDT;

    logic clk = 1'b0;
    logic por_n, supply_ok, wdi, wd_open;
    logic sys_rst_n;

    int n_cmp = 0;
    int n_bad = 0;

    supv_reset_ctrl #(
        .RELEASE_CYC (DLY),
        .TIMEOUT_CYC (WDT),
        .DIP_CYC     (DIP),
        .SYNC_STAGES (2)
    ) u_supv_reset_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .supply_ok (supply_ok),
        .wdi       (wdi),
        .wd_open   (wd_open),
        .sys_rst_n (sys_rst_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count negedges until sys_rst_n shows v (bounded).
    task automatic edges_until(input logic v, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sys_rst_n !== v && n < LIM);
    endtask

    // Hold for n cycles, report a mismatch if the output ever leaves v.
    task automatic stays(input string tag, input logic v, input int n);
        int bad;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sys_rst_n !== v) bad++;
        end
        check(tag, bad, 0);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        int n;
        por_n = 1'b0; supply_ok = 1'b0; wdi = 1'b0; wd_open = 1'b0;

        // R1: reset state under power-on, with the supply bad and then good.
        step(4);
        check("R1 por with supply low", int'(sys_rst_n), 0);
        supply_ok = 1'b1;
        step(3);
        check("R1 por with supply high", int'(sys_rst_n), 0);

        // R2: release latency from power-on with supply good.
        por_n = 1'b1;
        edges_until(1'b1, n);
        check("R2 release latency", n, DLY + 3);

        // R8/R6: unserviced timeout measured from release, then pulse length.
        edges_until(1'b0, n);
        check("R8 timeout from release", n, WDT);
        step(2);
        wdi = ~wdi;
        edges_until(1'b1, n);
        check("R6 timeout reset length", n, DLY - 2);
        edges_until(1'b0, n);
        check("R8 window cleared during reset", n, WDT);
        edges_until(1'b1, n);
        check("R6 second pulse length", n, DLY);

        // R5: sweep service intervals, alternating final edge polarity.
        for (int k = 0; k < 4; k++) begin
            int gap;
            gap = (k == 0) ? 1 : (k == 1) ? 7 : (k == 2) ? WDT / 2 : WDT - 1;
            for (int t = 0; t < 3 + (k % 2); t++) begin
                wdi = ~wdi;
                stays($sformatf("R5 serviced gap %0d", gap), 1'b1, gap);
            end
            wdi = ~wdi;
            edges_until(1'b0, n);
            check($sformatf("R5 timeout after %s edge", wdi ? "rising" : "falling"),
                  n, WDT + 3);
            edges_until(1'b1, n);
            check("R6 pulse after serviced run", n, DLY);
        end

        // R7: open strap, no service at all for several windows.
        wd_open = 1'b1;
        stays("R7 open strap no timeout", 1'b1, 4 * WDT);
        wdi = ~wdi;
        stays("R7 open strap after toggle", 1'b1, 2 * WDT);

        // R4: dips shorter than the filter limit are ignored.
        for (int len = 1; len < DIP; len++) begin
            supply_ok = 1'b0;
            step(len);
            supply_ok = 1'b1;
            stays($sformatf("R4 dip of %0d ignored", len), 1'b1, len + DIP + 6);
        end

        // R4: dip of exactly the limit is a failure, then normal release.
        supply_ok = 1'b0;
        step(DIP);
        supply_ok = 1'b1;
        edges_until(1'b0, n);
        check("R4 dip at limit latency", DIP + n, DIP + 3);
        edges_until(1'b1, n);
        check("R2 release after limit dip", n, DLY);

        // R4: long failure latency.
        supply_ok = 1'b0;
        edges_until(1'b0, n);
        check("R4 long failure latency", n, DIP + 3);

        // R3: failure during the delay restarts it.
        supply_ok = 1'b1;
        stays("R3 reset held in first delay", 1'b0, DLY / 2);
        supply_ok = 1'b0;
        stays("R3 reset held during dip", 1'b0, DIP + 1);
        supply_ok = 1'b1;
        edges_until(1'b1, n);
        check("R3 restarted delay", n, DLY + 3);

        // R1: power-on flag forces reset on the next edge.
        por_n = 1'b0;
        step(1);
        check("R1 por reasserts reset", int'(sys_rst_n), 0);
        stays("R1 por holds reset", 1'b0, 5);

        summary();
        $finish;
    end

endmodule